// File: doc/BRIEF.md
# Polled Console Device Registers

This block sits on a 16-bit processor's load/store bus and exposes a keyboard input channel and a display output channel as four fixed device registers. Software polls a status register for each channel: the ready flag occupies the sign bit, so a signed test of the loaded word tells whether the channel is ready, and the other bits read as zero.

On the device side, received characters arrive on an 8-bit valid/ready stream. The block holds one of them until software reads the keyboard data register. Characters stored to the display data register leave on a second 8-bit valid/ready stream. A pending character is held off rather than dropped. A display byte is held on the output stream until the stream accepts it. Read data is registered and appears the cycle after the read request.

Top module: `console_regs`

## Requirements
- R1: After reset the keyboard status register reads 0x0000, the display status register reads 0x8000, `kb_ready` is 1 and `dp_valid` is 0.
- R2: The keyboard status register at 0xFE00 reads 0x8000 while a received character is unread and 0x0000 otherwise.
- R3: A read of the keyboard data register at 0xFE02 returns the held character in bits 7:0, with bits 15:8 zero.
- R4: A read of 0xFE02 clears the keyboard pending flag, and `kb_ready` is 1 in the following cycle.
- R5: A character is accepted on a cycle where `kb_valid` and `kb_ready` are both 1. While a character is unread, `kb_ready` is 0, and a further character offered on `kb_data` does not replace the held one.
- R6: A store to the display data register at 0xFE06 while the display status reads 0x8000 makes `dp_valid` 1 with `dp_data` equal to bits 7:0 of the store data in the next cycle. The display status register at 0xFE04 then reads 0x0000.
- R7: `dp_valid` and `dp_data` hold until a cycle with `dp_ready` 1. After that cycle `dp_valid` is 0 and the display status reads 0x8000.
- R8: A store to 0xFE06 while a display byte is still in flight is ignored: `dp_data` keeps the earlier byte.
- R9: A read of any address other than the four registers returns 0x0000, and `bus_rdata` is 0x0000 in the cycle after any cycle without a read.
- R10: `bus_rdata` carries the result of a read in the cycle after the one in which `bus_rd` was 1, and reflects the register state before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Load/store address |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Registered read data |
| kb_valid | input | 1 | Received character offered |
| kb_data | input | 8 | Received character |
| kb_ready | output | 1 | Block can take a character |
| dp_valid | output | 1 | Display byte offered |
| dp_data | output | 8 | Display byte |
| dp_ready | input | 1 | Display stream accepts the byte |

## Verification
Every result is due one clock edge after its stimulus. Read data, the pending and busy flags, `kb_ready` and `dp_valid` all change at the edge that samples the request or handshake. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples outputs on the next falling edge. A status read issued in the cycle right after a handshake therefore sees the updated flag. Random characters, store data and unmapped addresses come from a seeded generator. Expected words come from a bench model of the pending and busy flags.

// File: rtl/console_regs.sv
module console_regs #(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          CW       = 8,
  parameter logic [15:0] KB_STAT  = 16'hFE00,
  parameter logic [15:0] KB_DATA  = 16'hFE02,
  parameter logic [15:0] DP_STAT  = 16'hFE04,
  parameter logic [15:0] DP_DATA  = 16'hFE06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          kb_valid,
  input  logic [CW-1:0] kb_data,
  output logic          kb_ready,
  output logic          dp_valid,
  output logic [CW-1:0] dp_data,
  input  logic          dp_ready
);

  localparam int PADW = DW - CW;

  logic          kb_full;
  logic [CW-1:0] kb_byte;
  logic          dp_busy;
  logic [CW-1:0] dp_byte;
  logic [DW-1:0] rd_mux;

  wire kb_take  = kb_valid && !kb_full;
  wire kb_drain = bus_rd && (bus_addr == AW'(KB_DATA));
  wire dp_load  = bus_wr && (bus_addr == AW'(DP_DATA)) && !dp_busy;
  wire dp_done  = dp_busy && dp_ready;

  assign kb_ready = !kb_full;
  assign dp_valid = dp_busy;
  assign dp_data  = dp_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kb_full <= 1'b0;
      kb_byte <= '0;
    end else if (kb_take) begin
      kb_full <= 1'b1;
      kb_byte <= kb_data;
    end else if (kb_drain) begin
      kb_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_busy <= 1'b0;
      dp_byte <= '0;
    end else if (dp_load) begin
      dp_busy <= 1'b1;
      dp_byte <= bus_wdata[CW-1:0];
    end else if (dp_done) begin
      dp_busy <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(KB_STAT))      rd_mux[DW-1] = kb_full;
    else if (bus_addr == AW'(KB_DATA)) rd_mux = {{PADW{1'b0}}, kb_byte};
    else if (bus_addr == AW'(DP_STAT)) rd_mux[DW-1] = !dp_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

endmodule

// File: rtl/console_regs_chk.sv
module console_regs_chk #(
  parameter int          AW      = 16,
  parameter int          DW      = 16,
  parameter int          CW      = 8,
  parameter logic [15:0] KB_DATA = 16'hFE02,
  parameter logic [15:0] DP_DATA = 16'hFE06
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          kb_valid,
  input logic          kb_ready,
  input logic          dp_valid,
  input logic [CW-1:0] dp_data,
  input logic          dp_ready
);

  p_kb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && kb_ready) |=> !kb_ready);

  p_kb_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(KB_DATA)) |=> kb_ready);

  p_dp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(DP_DATA) && !dp_valid)
      |=> (dp_valid && dp_data == $past(bus_wdata[CW-1:0])));

  p_dp_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !dp_ready) |=> (dp_valid && $stable(dp_data)));

  p_dp_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_ready) |=> !dp_valid);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind console_regs console_regs_chk #(
  .AW(AW), .DW(DW), .CW(CW), .KB_DATA(KB_DATA), .DP_DATA(DP_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .kb_valid(kb_valid), .kb_ready(kb_ready), .dp_valid(dp_valid),
  .dp_data(dp_data), .dp_ready(dp_ready)
);

// File: tb/console_regs_tb.sv
`timescale 1ns/1ps
module console_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_data = '0;
  logic        kb_ready;
  logic        dp_valid;
  logic [7:0]  dp_data;
  logic        dp_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       m_kb_full = 1'b0;
  logic [7:0] m_kb_byte = '0;
  logic       m_dp_busy = 1'b0;
  logic [7:0] m_dp_byte = '0;

  always #2 clk = ~clk;

  console_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
    .dp_valid(dp_valid), .dp_data(dp_data), .dp_ready(dp_ready)
  );

  function automatic logic [15:0] model_read(input logic [15:0] a);
    case (a)
      16'hFE00: return {m_kb_full, 15'h0};
      16'hFE02: return {8'h00, m_kb_byte};
      16'hFE04: return {!m_dp_busy, 15'h0};
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input string req, input logic [15:0] a);
    logic [15:0] exp;
    exp = model_read(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
    if (a == 16'hFE02) m_kb_full = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 16'hFE06 && !m_dp_busy) begin
      m_dp_busy = 1'b1; m_dp_byte = d[7:0];
    end
  endtask

  task automatic kb_offer(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = c;
    @(negedge clk);
    kb_valid = 1'b0;
    if (!m_kb_full) begin
      m_kb_full = 1'b1; m_kb_byte = c;
    end
  endtask

  task automatic dp_accept();
    @(negedge clk);
    dp_ready = 1'b1;
    @(negedge clk);
    dp_ready = 1'b0;
    m_dp_busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 kb_ready", {15'h0, kb_ready}, 16'h0001);
    check("R1 dp_valid", {15'h0, dp_valid}, 16'h0000);
    bus_read("R1 kb status", 16'hFE00);
    bus_read("R1 dp status", 16'hFE04);
    @(negedge clk);
    check("R9 idle rdata", bus_rdata, 16'h0000);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      kb_offer(c);
      check("R5 kb_ready low", {15'h0, kb_ready}, 16'h0000);
      bus_read("R2 kb status pending", 16'hFE00);
      if (i % 5 == 0) begin
        kb_offer(~c);
        check("R5 still held off", {15'h0, kb_ready}, 16'h0000);
      end
      bus_read("R3 kb data", 16'hFE02);
      check("R4 kb_ready back", {15'h0, kb_ready}, 16'h0001);
      bus_read("R2 kb status clear", 16'hFE00);
    end

    for (int i = 0; i < 30; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      bus_write(16'hFE06, d);
      check("R6 dp_valid", {15'h0, dp_valid}, 16'h0001);
      check("R6 dp_data", {8'h0, dp_data}, {8'h0, m_dp_byte});
      bus_read("R6 dp status busy", 16'hFE04);
      if (i % 3 == 0) begin
        bus_write(16'hFE06, ~d);
        check("R8 byte kept", {8'h0, dp_data}, {8'h0, d[7:0]});
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
      check("R7 held", {7'h0, dp_valid, dp_data}, {7'h0, 1'b1, d[7:0]});
      dp_accept();
      check("R7 dp_valid low", {15'h0, dp_valid}, 16'h0000);
      bus_read("R7 dp status ready", 16'hFE04);
    end

    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (i < 4) a = 16'hFE01 + 16'(i * 2);
      if (a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04) a = a + 16'h1;
      if (a == 16'hFE06) a = 16'hFE08;
      bus_read("R9 unmapped", a);
    end

    kb_offer(8'hA5);
    @(negedge clk);
    bus_addr = 16'hFE02; bus_rd = 1'b1;
    @(negedge clk);
    bus_addr = 16'hFE00;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 status after drain", bus_rdata, 16'h0000);
    m_kb_full = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule